// File: doc/BRIEF.md
# Six-Pin Bidirectional Port with Weak Pull-Ups

This block is the general purpose pin port of a small controller. Software reaches it through a simple register bus: an address, a write strobe, write data, and combinational read data. The bus also offers single-bit set and clear commands on the port latch. The block keeps an output latch, a direction register, a per-pin pull-up enable register, a per-pin analog-select mask and a global pull-up disable bit. From these it drives the pad output enables, the pad output values and the pad pull-up enables. The pad input levels pass through a synchroniser before software can read them.

Pin 3 can only be an input. A configuration input, `rst_pin_en`, can turn it into the chip reset pin. In that mode its pull-up is forced on and it reads as 0. A pin marked analog reads as 0, but its direction bit still controls its driver. Every pull-up is forced off on a pin that drives, and all of them are forced off while the global disable is set.

A bit set or bit clear is a read-modify-write built on the pin levels, not on the latch. A small controller with three states runs it:
- **IDLE → SAMPLE**: a bit command is accepted.
- **IDLE → IDLE**: no bit command is present.
- **SAMPLE → MERGE**: unconditional. The synchronised, masked pin levels are captured in this step.
- **MERGE → IDLE**: unconditional. The captured value, with the selected bit forced, is written to the whole latch.

Top module: `gpio_port`

## Requirements
- R1: Bits 7:6 of the port register (address 0) read as 0, and addresses 5 to 7 read as 0.
- R2: The direction register sits at address 1, and bit i controls pin i. A 1 makes the pin an input (`pad_oe[i]`=0). A 0 drives the latch bit onto `pad_out[i]` with `pad_oe[i]`=1.
- R3: Pin 3 is input only. Bit 3 of the direction register always reads 1, and `pad_oe[3]` and `pad_out[3]` are always 0.
- R4: A read of address 0 returns the pad levels delayed by two rising clock edges. A pin whose bit is set in the analog mask (address 3, bit i = pin i) reads 0.
- R5: A write to address 0 loads only the output latch (bits 5:0). The read value still follows the pins.
- R6: The pull-up enables sit at address 2, and bit 3 there reads 0. For pins other than 3, `pad_pu[i]` = enable AND direction bit AND NOT global disable. It is therefore off on any output pin.
- R7: The global pull-up disable is bit 0 at address 4 and is active high. While it is 1, `pad_pu` is 0 on every pin except pin 3.
- R8: With `rst_pin_en`=1, `pad_pu[3]`=1 and pin 3 reads 0. With `rst_pin_en`=0, `pad_pu[3]`=0 and pin 3 reads its level.
- R9: A pin selected as analog with direction bit 0 is still driven, and it still reads 0.
- R10: After reset, the latch is 0 (so bits 1:0 are cleared) and `pad_out` is 0. Direction reads 0x3F, pull-up enables read 0x37, the analog mask reads 0x3F and address 4 reads 0x01.
- R11: `bus_bset` (or `bus_bclr`) with `bus_bsel` starts a read-modify-write. The edge that accepts it, the next edge (pin capture) and the third edge (latch write) step through SAMPLE and MERGE. `pad_out` shows the new latch after the third edge. The new latch is the captured read value of all pins with the selected bit set (or cleared), so analog pins come back as 0. Set wins if both commands are high.
- R12: While a read-modify-write is in SAMPLE or MERGE, register writes and new bit commands are ignored. A bit command in the same cycle as a write drops the write.
- R13: A bit command with `bus_bsel` 6 or 7 still runs. The latch is loaded with the captured pin read value, unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_pin_en | input | 1 | Pin 3 serves as reset pin (configuration) |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_bset | input | 1 | Bit-set command on the port latch |
| bus_bclr | input | 1 | Bit-clear command on the port latch |
| bus_bsel | input | 3 | Bit index for set/clear |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pad_in | input | 6 | Pad input levels |
| pad_oe | output | 6 | Pad output enables |
| pad_out | output | 6 | Pad output values |
| pad_pu | output | 6 | Pad weak pull-up enables |

## Verification
The assertions assume that `rst_pin_en` is a static configuration that changes only between bus accesses. They also assume that `bus_addr` and the write and command strobes are settled well before each rising edge. The bench drives every input one nanosecond after a rising edge, so each value is stable for the whole cycle. It also changes the reset-pin configuration only while the bus is idle. Pad levels are held for at least two edges before any read that is expected to see them, so the synchroniser delay never overlaps a check.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_PINS = 3'd0;
    localparam logic [REG_AW-1:0] A_DIR  = 3'd1;
    localparam logic [REG_AW-1:0] A_PULL = 3'd2;
    localparam logic [REG_AW-1:0] A_ANA  = 3'd3;
    localparam logic [REG_AW-1:0] A_CTRL = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_MERGE  = 2'd2
    } rmw_state_e;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g] <= '0;
            end else begin
                if (g == 0) chain[g] <= d;
                else        chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_cfg.sv
module gpio_port_cfg
    import gpio_port_pkg::*;
#(
    parameter int PINS        = 6,
    parameter int DW          = 8,
    parameter int IN_ONLY_PIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [PINS-1:0]   dir,
    output logic [PINS-1:0]   pull_en,
    output logic [PINS-1:0]   ana,
    output logic              gpd
);

    localparam logic [PINS-1:0] IN_MASK = PINS'(1) << IN_ONLY_PIN;

    logic unused_hi;
    assign unused_hi = ^wdata[DW-1:PINS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir     <= '1;
            pull_en <= ~IN_MASK;
            ana     <= '1;
            gpd     <= 1'b1;
        end else if (wr_en) begin
            case (addr)
                A_DIR:   dir     <= wdata[PINS-1:0] | IN_MASK;
                A_PULL:  pull_en <= wdata[PINS-1:0] & ~IN_MASK;
                A_ANA:   ana     <= wdata[PINS-1:0];
                A_CTRL:  gpd     <= wdata[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_rmw.sv
module gpio_port_rmw
    import gpio_port_pkg::*;
#(
    parameter int PINS = 6,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            go_set,
    input  logic [SELW-1:0] go_sel,
    input  logic            port_wr,
    input  logic [PINS-1:0] port_wdata,
    input  logic [PINS-1:0] pin_rd,
    output logic [PINS-1:0] latch,
    output logic            busy
);

    rmw_state_e      state, nxt;
    logic [SELW-1:0] sel_q;
    logic            set_q;
    logic [PINS-1:0] snap_q;
    logic [PINS-1:0] merged;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = ST_IDLE;
        unique case (state)
            ST_IDLE:   nxt = go ? ST_SAMPLE : ST_IDLE;
            ST_SAMPLE: nxt = ST_MERGE;
            ST_MERGE:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        merged = snap_q;
        for (int i = 0; i < PINS; i++) begin
            if (sel_q == SELW'(i)) merged[i] = set_q;
        end
    end

    // per-state actions on the latch and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch  <= '0;
            snap_q <= '0;
            sel_q  <= '0;
            set_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        sel_q <= go_sel;
                        set_q <= go_set;
                    end else if (port_wr) begin
                        latch <= port_wdata;
                    end
                end
                ST_SAMPLE: snap_q <= pin_rd;
                ST_MERGE:  latch  <= merged;
                default: ;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
    parameter int PINS        = 6,
    parameter int IN_ONLY_PIN = 3
) (
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] latch,
    input  logic [PINS-1:0] pull_en,
    input  logic [PINS-1:0] ana,
    input  logic            gpd,
    input  logic            rst_pin_en,
    input  logic [PINS-1:0] pin_sync,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_pu,
    output logic [PINS-1:0] pin_rd
);

    logic unused_in_only;
    assign unused_in_only = dir[IN_ONLY_PIN] ^ latch[IN_ONLY_PIN] ^ pull_en[IN_ONLY_PIN];

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        if (i == IN_ONLY_PIN) begin : g_in_only
            assign pad_oe[i]  = 1'b0;
            assign pad_out[i] = 1'b0;
            assign pad_pu[i]  = rst_pin_en;
            assign pin_rd[i]  = ~rst_pin_en & pin_sync[i] & ~ana[i];
        end else begin : g_io
            assign pad_oe[i]  = ~dir[i];
            assign pad_out[i] = latch[i];
            assign pad_pu[i]  = pull_en[i] & dir[i] & ~gpd;
            assign pin_rd[i]  = pin_sync[i] & ~ana[i];
        end
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int PINS        = 6,
    parameter int DW          = 8,
    parameter int IN_ONLY_PIN = 3,
    parameter int SYNC_STAGES = 2,
    parameter int SELW        = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_pin_en,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_bset,
    input  logic              bus_bclr,
    input  logic [SELW-1:0]   bus_bsel,
    output logic [DW-1:0]     bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_pu
);

    logic [PINS-1:0] pin_sync, pin_rd, ctl_dir, ctl_pull, ctl_ana, latch;
    logic            ctl_gpd, rmw_busy, bit_cmd, bit_go, reg_wr, port_wr;

    assign bit_cmd = bus_bset | bus_bclr;
    assign bit_go  = bit_cmd & ~rmw_busy;
    assign reg_wr  = bus_we & ~bit_cmd & ~rmw_busy;
    assign port_wr = reg_wr & (bus_addr == A_PINS);

    gpio_port_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
    );

    gpio_port_cfg #(.PINS(PINS), .DW(DW), .IN_ONLY_PIN(IN_ONLY_PIN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(bus_addr), .wdata(bus_wdata),
        .dir(ctl_dir), .pull_en(ctl_pull), .ana(ctl_ana), .gpd(ctl_gpd)
    );

    gpio_port_rmw #(.PINS(PINS), .SELW(SELW)) u_rmw (
        .clk(clk), .rst_n(rst_n), .go(bit_go), .go_set(bus_bset), .go_sel(bus_bsel),
        .port_wr(port_wr), .port_wdata(bus_wdata[PINS-1:0]), .pin_rd(pin_rd),
        .latch(latch), .busy(rmw_busy)
    );

    gpio_port_pad #(.PINS(PINS), .IN_ONLY_PIN(IN_ONLY_PIN)) u_pad (
        .dir(ctl_dir), .latch(latch), .pull_en(ctl_pull), .ana(ctl_ana), .gpd(ctl_gpd),
        .rst_pin_en(rst_pin_en), .pin_sync(pin_sync),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pin_rd(pin_rd)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_PINS:  bus_rdata[PINS-1:0] = pin_rd;
            A_DIR:   bus_rdata[PINS-1:0] = ctl_dir;
            A_PULL:  bus_rdata[PINS-1:0] = ctl_pull;
            A_ANA:   bus_rdata[PINS-1:0] = ctl_ana;
            A_CTRL:  bus_rdata[0]        = ctl_gpd;
            default: bus_rdata           = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int PINS        = 6,
    parameter int DW          = 8,
    parameter int IN_ONLY_PIN = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_pin_en,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_we,
    input logic [DW-1:0]     bus_rdata,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_pu,
    input logic              rmw_busy,
    input logic              ctl_gpd,
    input logic [PINS-1:0]   ctl_dir
);

    localparam logic [PINS-1:0] IN_MASK = PINS'(1) << IN_ONLY_PIN;

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_PINS) |-> (bus_rdata[DW-1:PINS] == '0));

    p_in_only_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[IN_ONLY_PIN]);

    p_dir_bit_reads_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DIR) |-> bus_rdata[IN_ONLY_PIN]);

    p_no_pull_on_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0);

    p_global_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_gpd |-> ((pad_pu & ~IN_MASK) == '0));

    p_reset_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin_en |-> (pad_pu[IN_ONLY_PIN] && (bus_addr != A_PINS || !bus_rdata[IN_ONLY_PIN])));

    p_rmw_length_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rmw_busy) |=> rmw_busy ##1 !rmw_busy);

    p_busy_blocks_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_busy && bus_we && bus_addr == A_DIR) |=> $stable(ctl_dir));

endmodule

bind gpio_port gpio_port_chk #(.PINS(PINS), .DW(DW), .IN_ONLY_PIN(IN_ONLY_PIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_pin_en(rst_pin_en), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .pad_oe(pad_oe), .pad_pu(pad_pu), .rmw_busy(rmw_busy),
    .ctl_gpd(ctl_gpd), .ctl_dir(ctl_dir)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_pin_en = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_bset = 1'b0, bus_bclr = 1'b0;
    logic [2:0] bus_bsel = '0;
    logic [7:0] bus_rdata;
    logic [5:0] pad_in = 6'h2A;
    logic [5:0] pad_oe, pad_out, pad_pu;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .rst_pin_en(rst_pin_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_bset(bus_bset), .bus_bclr(bus_bclr),
        .bus_bsel(bus_bsel), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // behavioural reference
    logic [5:0] m_latch, m_dir, m_pull, m_ana, m_snap, m_s1, m_s2, m_rd;
    logic       m_gpd, m_set;
    int         m_phase, m_sel;

    function automatic logic [5:0] m_pins();
        logic [5:0] v;
        v = m_s2 & ~m_ana;
        if (rst_pin_en) v[3] = 1'b0;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_latch = 6'h00; m_dir = 6'h3F; m_pull = 6'h37; m_ana = 6'h3F; m_gpd = 1'b1;
            m_phase = 0; m_sel = 0; m_set = 1'b0; m_snap = 6'h00; m_s1 = 6'h00; m_s2 = 6'h00;
        end else begin
            m_rd = m_pins();
            if (m_phase == 0) begin
                if (bus_bset || bus_bclr) begin
                    m_sel = int'(bus_bsel); m_set = bus_bset; m_phase = 1;
                end else if (bus_we) begin
                    case (bus_addr)
                        3'd0: m_latch = bus_wdata[5:0];
                        3'd1: m_dir   = bus_wdata[5:0] | 6'h08;
                        3'd2: m_pull  = bus_wdata[5:0] & 6'h37;
                        3'd3: m_ana   = bus_wdata[5:0];
                        3'd4: m_gpd   = bus_wdata[0];
                        default: ;
                    endcase
                end
            end else if (m_phase == 1) begin
                m_snap = m_rd; m_phase = 2;
            end else begin
                m_latch = m_snap;
                if (m_sel < 6) m_latch[m_sel] = m_set;
                m_phase = 0;
            end
            m_s2 = m_s1; m_s1 = pad_in;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] er;
            er = 8'h00;
            case (bus_addr)
                3'd0: er = {2'b00, m_pins()};
                3'd1: er = {2'b00, m_dir};
                3'd2: er = {2'b00, m_pull};
                3'd3: er = {2'b00, m_ana};
                3'd4: er = {7'b0, m_gpd};
                default: er = 8'h00;
            endcase
            chk("R4 read data (model)", bus_rdata, er);
            chk("R2 pad_oe (model)", {2'b00, pad_oe}, {2'b00, ~m_dir & 6'h37});
            chk("R3 pad_out (model)", {2'b00, pad_out}, {2'b00, m_latch & 6'h37});
            chk("R6 pad_pu (model)", {2'b00, pad_pu},
                {2'b00, (m_pull & m_dir & {6{~m_gpd}} & 6'h37) | {2'b00, rst_pin_en, 3'b000}});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic bitop(input logic s, input logic [2:0] sel);
        @(posedge clk); #1;
        bus_bset = s; bus_bclr = ~s; bus_bsel = sel;
        @(posedge clk); #1;
        bus_bset = 1'b0; bus_bclr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pads(input logic [5:0] v);
        @(posedge clk); #1;
        pad_in = v;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        chk("R10 pad_out reset", {2'b00, pad_out}, 8'h00);
        chk("R10 pad_oe reset", {2'b00, pad_oe}, 8'h00);
        chk("R7 R8 pad_pu reset", {2'b00, pad_pu}, 8'h08);
        rd_chk(3'd0, 8'h00, "R10 analog mask reads pins 0");
        rd_chk(3'd1, 8'h3F, "R10 direction reset");
        rd_chk(3'd2, 8'h37, "R10 pull enable reset");
        rd_chk(3'd3, 8'h3F, "R10 analog reset");
        rd_chk(3'd4, 8'h01, "R10 global disable reset");
        rd_chk(3'd5, 8'h00, "R1 unused address");
        rd_chk(3'd7, 8'h00, "R1 unused address");

        wr(3'd3, 8'h00);
        wr(3'd4, 8'h00);
        #2 chk("R6 R8 pulls on", {2'b00, pad_pu}, 8'h3F);
        rd_chk(3'd0, 8'h22, "R8 reset pin reads 0");
        @(posedge clk); #1 rst_pin_en = 1'b0;
        #2 chk("R8 pin 3 pull off", {2'b00, pad_pu}, 8'h37);
        rd_chk(3'd0, 8'h2A, "R8 pin 3 level");

        wr(3'd1, 8'h00);
        rd_chk(3'd1, 8'h08, "R3 dir bit 3 stays 1");
        chk("R2 outputs enabled", {2'b00, pad_oe}, 8'h37);
        chk("R6 pull off on outputs", {2'b00, pad_pu}, 8'h00);
        wr(3'd0, 8'h15);
        #2 chk("R5 latch drives", {2'b00, pad_out}, 8'h15);
        rd_chk(3'd0, 8'h2A, "R5 read follows pins");
        wr(3'd0, 8'hFF);
        #2 chk("R3 pin 3 never driven", {2'b00, pad_out}, 8'h37);
        rd_chk(3'd0, 8'h2A, "R1 upper bits zero");

        wr(3'd1, 8'h3F);
        wr(3'd4, 8'h01);
        #2 chk("R7 global disable", {2'b00, pad_pu}, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h01);
        wr(3'd1, 8'h3E);
        #2 chk("R9 analog pin driven", {2'b00, pad_oe}, 8'h01);
        chk("R6 pull gating", {2'b00, pad_pu}, 8'h36);
        pads(6'h2B);
        rd_chk(3'd0, 8'h2A, "R9 analog pin reads 0");

        wr(3'd3, 8'h00);
        pads(6'h2B);
        @(posedge clk); #1 pad_in = 6'h15;
        rd_chk(3'd0, 8'h2B, "R4 one edge: old level");
        rd_chk(3'd0, 8'h15, "R4 two edges: new level");

        wr(3'd1, 8'h00);
        bitop(1'b0, 3'd4);
        @(posedge clk); #2;
        chk("R11 latch not yet written", {2'b00, pad_out}, 8'h37);
        @(posedge clk); #2;
        chk("R11 clear from pin levels", {2'b00, pad_out}, 8'h05);

        wr(3'd3, 8'h02);
        pads(6'h3F);
        bitop(1'b1, 3'd2);
        repeat (2) @(posedge clk);
        #2 chk("R11 analog bit cleared by rmw", {2'b00, pad_out}, 8'h35);

        bitop(1'b0, 3'd5);
        wr(3'd1, 8'h3F);
        rd_chk(3'd1, 8'h08, "R12 write ignored while busy");
        chk("R12 rmw result", {2'b00, pad_out}, 8'h15);

        wr(3'd3, 8'h00);
        pads(6'h0B);
        bitop(1'b1, 3'd7);
        repeat (2) @(posedge clk);
        #2 chk("R13 out-of-range bit copies pins", {2'b00, pad_out}, 8'h03);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule